// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up and Deep-Power-Down Sequencer

This block sits on the controller side of a low-power SDRAM and owns the command pins while the memory is brought to life. After reset it keeps the clock enable low and the device deselected. It then waits for a start pulse. From there it runs the mandatory bring-up: a long stable-clock wait filled with NOPs, a precharge of every bank, a fixed number of auto-refresh commands, a load of the main mode register and a load of the extended mode register. After the last load it raises `ready_o` and parks on NOP.

While ready, a deep-power-down request puts the device into its lowest-power state, which discards all array contents. If the controller reports an open bank, a precharge of every bank and its recovery gap come first. The wake request is honoured only in that state. Waking raises the clock enable and replays the entire bring-up, with the opcodes sampled again when each register load is issued. Every wait is a parameter counted in clocks, so a bench can shrink the stable-clock wait. Requests that arrive at the wrong moment are dropped.

Top module: `lpsdram_pwr_seq`

## Requirements
- R1: While reset is applied and until the first start pulse, CKE is low, CS_n is high and `ready_o` is low.
- R2: A start pulse seen in the reset-idle state raises CKE on the next edge. NOP (CS_n,RAS_n,CAS_n,WE_n = 0,1,1,1) is then driven for PWR_CYC cycles, and the first cycle with CKE high is a NOP.
- R3: After the stable-clock wait, one precharge-all is issued (pins 0,0,1,0 with `addr_o[10]`=1), followed by TRP_CYC-1 NOP cycles.
- R4: Next come exactly NREF auto-refresh commands (pins 0,0,0,1). Each is followed by TRC_CYC-1 NOP cycles.
- R5: The mode register load drives all four command pins low with `ba_o`=00. It places `mode_op_i` on `addr_o[6:0]` (burst length in [2:0]: 000=1, 001=2, 010=4, 011=8, 111=full page; burst type in [3]: 0 sequential, 1 interleave; CAS latency in [6:4]: 001..011 = 1..3), with `addr_o[11:7]`=0.
- R6: The extended register load drives all four command pins low with `ba_o`=10. It places `ext_op_i` on `addr_o[4:0]` (array coverage in [2:0], temperature range in [4:3]), with the other address bits 0.
- R7: Each register load is followed by TMRD_CYC-1 NOP cycles before the next command. `ready_o` rises TMRD_CYC cycles after the extended load.
- R8: `ready_o` is high only in the operating state, where the pins hold NOP with CKE high. It is low throughout bring-up and deep power down.
- R9: A deep-power-down request while ready with `banks_open_i` low yields, on the next edge, pins 0,1,1,0 with CKE going low. Afterwards CS_n is high and CKE stays low.
- R10: With `banks_open_i` high, the request first yields a precharge-all and TRP_CYC-1 NOP cycles, and then the deep-power-down entry of R9.
- R11: A wake request in deep power down raises CKE with NOP on the next edge. The full sequence of R2 to R7 then repeats, using the opcodes present at each register load.
- R12: A start or deep-power-down request is ignored while `ready_o` is low. A wake request is ignored outside deep power down. Start is also ignored once the first bring-up has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the first bring-up |
| dpd_req_i | input | 1 | Request deep power down |
| wake_req_i | input | 1 | Request exit from deep power down |
| banks_open_i | input | 1 | Controller reports at least one open bank |
| mode_op_i | input | 7 | Main mode register opcode |
| ext_op_i | input | 5 | Extended mode register opcode |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Address bus |
| ready_o | output | 1 | Bring-up complete, memory usable |

## Verification
The assertions check several rules on every cycle:
- A rise of CKE is met by a NOP.
- A fall of CKE coincides with the deep-power-down command.
- A register load always carries BA0 low and is always followed by a NOP.
- Ready never coexists with a low CKE or a non-NOP command.
- A main register load never happens before the full refresh count.

Only the bench scenarios can show the exact ordering and lengths of the waits, the opcode placement on the address bus, the open-bank precharge detour, and the dropping of badly timed requests.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PREA,
    CMD_REF,
    CMD_MRS,
    CMD_EMRS,
    CMD_DPD
  } seq_cmd_e;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR_WAIT,
    ST_PRE_GAP,
    ST_REF_GAP,
    ST_MRS_GAP,
    ST_EMRS_GAP,
    ST_READY,
    ST_DPD_PRE_GAP,
    ST_DPD
  } seq_state_e;

  localparam logic [1:0] BA_MAIN = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b10;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_code(seq_cmd_e c);
    case (c)
      CMD_NOP:  cmd_code = 4'b0111;
      CMD_PREA: cmd_code = 4'b0010;
      CMD_REF:  cmd_code = 4'b0001;
      CMD_MRS:  cmd_code = 4'b0000;
      CMD_EMRS: cmd_code = 4'b0000;
      CMD_DPD:  cmd_code = 4'b0110;
      default:  cmd_code = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/lpseq_timer.sv
module lpseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
  import lpseq_pkg::*;
#(
  parameter int PWR_CYC  = 25000,
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 9,
  parameter int NREF     = 8,
  parameter int TMRD_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     dpd_req_i,
  input  logic     wake_req_i,
  input  logic     banks_open_i,
  output seq_cmd_e cmd_o,
  output logic     cke_o,
  output logic     ready_o
);
  localparam int MAXW  = (PWR_CYC > TRC_CYC) ? PWR_CYC : TRC_CYC;
  localparam int MAXG  = (MAXW > TRP_CYC) ? ((MAXW > TMRD_CYC) ? MAXW : TMRD_CYC)
                                          : ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC);
  localparam int CNT_W = $clog2(MAXG + 1);
  localparam int REF_W = $clog2(NREF + 1);
  localparam logic [CNT_W-1:0] PWR_LD  = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] TRC_LD  = CNT_W'(TRC_CYC - 1);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_CYC - 1);
  localparam logic [REF_W-1:0] REF_ALL = REF_W'(NREF);

  seq_state_e       state_q, state_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  lpseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    cmd_o    = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_OFF: begin
        cmd_o = CMD_DESEL;
        if (start_i) begin
          cmd_o    = CMD_NOP;
          state_d  = ST_PWR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = PWR_LD;
        end
      end
      ST_PWR_WAIT: if (tmr_done) begin
        cmd_o    = CMD_PREA;
        state_d  = ST_PRE_GAP;
        tmr_load = 1'b1;
        tmr_val  = TRP_LD;
      end
      ST_PRE_GAP: if (tmr_done) begin
        cmd_o    = CMD_REF;
        state_d  = ST_REF_GAP;
        ref_d    = REF_W'(1);
        tmr_load = 1'b1;
        tmr_val  = TRC_LD;
      end
      ST_REF_GAP: if (tmr_done) begin
        tmr_load = 1'b1;
        if (ref_q < REF_ALL) begin
          cmd_o   = CMD_REF;
          ref_d   = ref_q + 1'b1;
          tmr_val = TRC_LD;
        end else begin
          cmd_o   = CMD_MRS;
          state_d = ST_MRS_GAP;
          tmr_val = TMRD_LD;
        end
      end
      ST_MRS_GAP: if (tmr_done) begin
        cmd_o    = CMD_EMRS;
        state_d  = ST_EMRS_GAP;
        tmr_load = 1'b1;
        tmr_val  = TMRD_LD;
      end
      ST_EMRS_GAP: if (tmr_done) state_d = ST_READY;
      ST_READY: if (dpd_req_i) begin
        if (banks_open_i) begin
          cmd_o    = CMD_PREA;
          state_d  = ST_DPD_PRE_GAP;
          tmr_load = 1'b1;
          tmr_val  = TRP_LD;
        end else begin
          cmd_o   = CMD_DPD;
          state_d = ST_DPD;
        end
      end
      ST_DPD_PRE_GAP: if (tmr_done) begin
        cmd_o   = CMD_DPD;
        state_d = ST_DPD;
      end
      ST_DPD: begin
        cmd_o = CMD_DESEL;
        if (wake_req_i) begin
          cmd_o    = CMD_NOP;
          state_d  = ST_PWR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = PWR_LD;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign cke_o = (state_d != ST_OFF) && (state_d != ST_DPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  assign ready_o = (state_q == ST_READY);

  // R4
  ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (ref_q == REF_ALL));

  // R12
  wake_only_dpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && !dpd_req_i) |=> (state_q == ST_READY));

endmodule

// File: rtl/lpseq_pin_drv.sv
module lpseq_pin_drv
  import lpseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int MODE_W = 7,
  parameter int EXT_W  = 5,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd_i,
  input  logic              cke_i,
  input  logic [MODE_W-1:0] mode_op_i,
  input  logic [EXT_W-1:0]  ext_op_i,
  output logic              cke_o,
  output logic [3:0]        code_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  always_comb begin
    addr_d = '0;
    ba_d   = '0;
    case (cmd_i)
      CMD_PREA: addr_d[AP_BIT] = 1'b1;
      CMD_MRS: begin
        addr_d[MODE_W-1:0] = mode_op_i;
        ba_d               = BA_W'(BA_MAIN);
      end
      CMD_EMRS: begin
        addr_d[EXT_W-1:0] = ext_op_i;
        ba_d              = BA_W'(BA_EXT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o  <= 1'b0;
      code_o <= 4'b1111;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      cke_o  <= cke_i;
      code_o <= cmd_code(cmd_i);
      ba_o   <= ba_d;
      addr_o <= addr_d;
    end
  end

endmodule

// File: rtl/lpsdram_pwr_seq.sv
module lpsdram_pwr_seq
  import lpseq_pkg::*;
#(
  parameter int PWR_CYC  = 25000,
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 9,
  parameter int NREF     = 8,
  parameter int TMRD_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        dpd_req_i,
  input  logic        wake_req_i,
  input  logic        banks_open_i,
  input  logic [6:0]  mode_op_i,
  input  logic [4:0]  ext_op_i,
  output logic        cke_o,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [1:0]  ba_o,
  output logic [11:0] addr_o,
  output logic        ready_o
);
  seq_cmd_e   cmd;
  logic       cke_next;
  logic [3:0] code;

  lpseq_ctrl #(
    .PWR_CYC (PWR_CYC),
    .TRP_CYC (TRP_CYC),
    .TRC_CYC (TRC_CYC),
    .NREF    (NREF),
    .TMRD_CYC(TMRD_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dpd_req_i    (dpd_req_i),
    .wake_req_i   (wake_req_i),
    .banks_open_i (banks_open_i),
    .cmd_o        (cmd),
    .cke_o        (cke_next),
    .ready_o      (ready_o)
  );

  lpseq_pin_drv #(
    .ADDR_W(12), .BA_W(2), .MODE_W(7), .EXT_W(5), .AP_BIT(10)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .cke_i     (cke_next),
    .mode_op_i (mode_op_i),
    .ext_op_i  (ext_op_i),
    .cke_o     (cke_o),
    .code_o    (code),
    .ba_o      (ba_o),
    .addr_o    (addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = code;

  logic pin_nop, pin_load;
  assign pin_nop  = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);
  assign pin_load = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);

  // R2
  cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (pin_nop || cs_n_o));

  // R9
  cke_fall_dpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0110));

  // R5
  load_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_load |-> (ba_o[0] == 1'b0));

  // R7
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_load |=> pin_nop);

  // R8
  ready_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cke_o && pin_nop));

endmodule

// File: tb/lpsdram_pwr_seq_bench.sv
module lpsdram_pwr_seq_bench;
  localparam int PWR  = 12;
  localparam int TRP  = 3;
  localparam int TRC  = 4;
  localparam int NREF = 8;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, dpd_req_i = 0, wake_req_i = 0, banks_open_i = 0;
  logic [6:0] mode_op_i = '0;
  logic [4:0] ext_op_i = '0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o;
  logic [1:0] ba_o;
  logic [11:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  lpsdram_pwr_seq #(
    .PWR_CYC(PWR), .TRP_CYC(TRP), .TRC_CYC(TRC), .NREF(NREF), .TMRD_CYC(TMRD)
  ) u_lpsdram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dpd_req_i(dpd_req_i),
    .wake_req_i(wake_req_i), .banks_open_i(banks_open_i),
    .mode_op_i(mode_op_i), .ext_op_i(ext_op_i), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
  );

  task automatic pins(string req, logic e_cke, logic [3:0] e_cmd, logic e_rdy);
    logic [5:0] act, exp;
    act = {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o};
    exp = {e_cke, e_cmd, e_rdy};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {cke,cmd,ready} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus(string req, logic [1:0] e_ba, logic [11:0] e_addr);
    n_tests++;
    if ({ba_o, addr_o} !== {e_ba, e_addr}) begin
      n_fail++;
      $display("FAIL %s: ba/addr actual %b/%h expected %b/%h", req, ba_o, addr_o, e_ba, e_addr);
    end
  endtask

  task automatic nops(string req, int n);
    for (int i = 0; i < n; i++) begin
      pins(req, 1'b1, 4'b0111, 1'b0);
      @(negedge clk);
    end
  endtask

  // Entered at the negedge after the edge where CKE rose.
  task automatic init_seq(logic [6:0] m, logic [4:0] x, int inject);
    for (int i = 0; i < PWR; i++) begin
      start_i    = (i == inject);   // R12: ignored while not ready
      dpd_req_i  = (i == inject);
      wake_req_i = (i == inject);
      pins("R2 stable wait", 1'b1, 4'b0111, 1'b0);
      @(negedge clk);
    end
    start_i = 0; dpd_req_i = 0; wake_req_i = 0;
    pins("R3 precharge-all", 1'b1, 4'b0010, 1'b0);
    n_tests++;
    if (addr_o[10] !== 1'b1) begin
      n_fail++;
      $display("FAIL R3: A10 actual %b expected 1", addr_o[10]);
    end
    @(negedge clk);
    nops("R3 tRP gap", TRP - 1);
    for (int r = 0; r < NREF; r++) begin
      pins("R4 refresh", 1'b1, 4'b0001, 1'b0);
      @(negedge clk);
      nops("R4 tRC gap", TRC - 1);
    end
    pins("R5 mode load", 1'b1, 4'b0000, 1'b0);
    bus("R5 mode load", 2'b00, {5'b0, m});
    @(negedge clk);
    nops("R7 gap after mode load", TMRD - 1);
    pins("R6 ext load", 1'b1, 4'b0000, 1'b0);
    bus("R6 ext load", 2'b10, {7'b0, x});
    @(negedge clk);
    nops("R7 gap after ext load", TMRD - 1);
    pins("R7 R8 ready", 1'b1, 4'b0111, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pins("R1 in reset", 1'b0, 4'b1111, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: wake and deep-power-down requests before start are dropped
    dpd_req_i = 1; wake_req_i = 1;
    @(negedge clk);
    dpd_req_i = 0; wake_req_i = 0;
    repeat (2) @(negedge clk);
    pins("R1 R12 idle before start", 1'b0, 4'b1111, 1'b0);

    mode_op_i = 7'b010_0_011;   // CL2, sequential, burst 8
    ext_op_i  = 5'b11_001;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    init_seq(mode_op_i, ext_op_i, 3);

    // R12: wake and start while ready have no effect
    wake_req_i = 1; start_i = 1;
    @(negedge clk);
    wake_req_i = 0; start_i = 0;
    for (int i = 0; i < 3; i++) begin
      pins("R12 wake/start ignored when ready", 1'b1, 4'b0111, 1'b1);
      @(negedge clk);
    end

    for (int k = 1; k <= 4; k++) begin
      banks_open_i = k[0];
      dpd_req_i = 1;
      @(negedge clk);
      dpd_req_i = 0;
      if (banks_open_i) begin
        pins("R10 precharge before DPD", 1'b1, 4'b0010, 1'b0);
        bus("R10 precharge A10", 2'b00, 12'h400);
        @(negedge clk);
        nops("R10 tRP gap", TRP - 1);
      end
      pins("R9 DPD entry", 1'b0, 4'b0110, 1'b0);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        dpd_req_i = (i == 1); start_i = (i == 2);
        pins("R9 R12 held in DPD", 1'b0, 4'b1111, 1'b0);
        @(negedge clk);
      end
      dpd_req_i = 0; start_i = 0;
      mode_op_i = {3'(1 + (k % 3)), k[0], (k == 4) ? 3'b111 : 3'(k - 1)};
      ext_op_i  = {2'(k), 3'(k % 3)};
      wake_req_i = 1;
      @(negedge clk);
      wake_req_i = 0;
      // R11: wake replays the whole bring-up with the new opcodes
      init_seq(mode_op_i, ext_op_i, k + 4);
      @(negedge clk);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule